// File: doc/BRIEF.md
# Processor Stop-Clock Power State Controller

This block sequences the clock and voltage controls of a processor core through its idle states. Software can halt the core, and a hardware stop-clock pin can gate it. From the pin-gated state a deeper request can also shut down the PLL. The controller drives four enables: one for the core clock, one for the bus-interface and interrupt-controller clock domain, one for the PLL, and a request to the regulator for reduced voltage.

While the core is halted or pin-gated, a bus snoop request may briefly restore the core clock. When the snoop logic signals that it is done, the controller goes back by itself to the idle state it left. A configuration input selects extended idle states, which also lower the core voltage. A snoop taken from an extended state keeps the voltage low. On every return to full operation from an extended state, the low-voltage request is dropped one cycle before the core clock is re-enabled. When the PLL was shut down, the controller first waits a parameterized lock interval after turning it back on.

Top module: `pwr_state_ctl`

## Requirements
- R1: After reset the state output reads RUN (0), with core, bus and PLL enables at 1, the low-voltage request at 0 and the extended flag at 0.
- R2: In RUN, `stop_pin` high moves the controller to STOPGNT (2) at the next clock, with core enable 0 and bus and PLL enables 1. The pin takes priority over a simultaneous halt request.
- R3: In RUN, with `stop_pin` low, `halt_req` high moves the controller to HALT (1), with core enable 0 and bus and PLL enables 1.
- R4: `intr` high in HALT returns the controller to RUN. `stop_pin` low in STOPGNT also returns it to RUN. In both cases all enables come back.
- R5: In STOPGNT with `stop_pin` held high and no snoop, `deep_req` moves the controller to STOPCLK (3), where the core, bus and PLL enables are all 0.
- R6: `stop_pin` low in STOPCLK enters RELOCK (5). The PLL enable is 1 and the core enable is 0 for exactly LOCK_CYCLES cycles, and the controller then continues toward RUN.
- R7: `snoop_req` in HALT or STOPGNT enters SNOOP (4), with core, bus and PLL enables at 1. It takes priority over `intr` and `deep_req`. `snoop_done` returns the controller to the state it left.
- R8: `ext_en` is sampled when HALT or STOPGNT is entered from RUN. If it is 1, the extended flag output is 1 and the low-voltage request is 1 in HALT, STOPGNT, STOPCLK and RELOCK.
- R9: A snoop taken from an extended state keeps the low-voltage request at 1 and returns with the extended flag still set.
- R10: Leaving an extended state toward RUN passes through EXIT (6) for one cycle, with the core enable 0 and the low-voltage request 0. The next cycle is RUN, with the core enable 1 and the extended flag 0.
- R11: In STOPCLK, `snoop_req` is ignored and the state stays STOPCLK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| halt_req | input | 1 | Software halt request from the decoder |
| stop_pin | input | 1 | Hardware stop-clock level |
| deep_req | input | 1 | Request to also stop the PLL |
| snoop_req | input | 1 | External bus snoop request |
| snoop_done | input | 1 | Snoop handling finished |
| intr | input | 1 | Interrupt that ends a halt |
| ext_en | input | 1 | Select extended low-voltage idle states |
| core_clk_en | output | 1 | Core clock enable |
| bus_clk_en | output | 1 | Bus-interface / interrupt-controller clock enable |
| pll_en | output | 1 | PLL enable |
| lowv_req | output | 1 | Reduced-voltage request |
| state_o | output | 3 | Encoded state (RUN 0, HALT 1, STOPGNT 2, STOPCLK 3, SNOOP 4, RELOCK 5, EXIT 6) |
| ext_o | output | 1 | Extended-mode flag of the current idle episode |

## Verification
The state sequencing is exercised with three kinds of episode. The first is a plain software halt and a plain pin-gated stop. The second is a pin-gated stop that goes deep, so that the PLL is off and the relock wait is seen. The third repeats both the halt and the deep stop with the extended bit set. Simultaneous requests, such as pin with halt, snoop with deep request and snoop with interrupt, separate the priority orders. A snoop during the deep state shows that it is ignored there. The extended episodes separate a correct voltage-first exit from one that raises the core clock while the voltage is still low.

// File: rtl/pwr_state_pkg.sv
package pwr_state_pkg;
   localparam int STATE_W = 3;

   typedef enum logic [STATE_W-1:0] {
      PS_RUN     = 3'd0,
      PS_HALT    = 3'd1,
      PS_STOPGNT = 3'd2,
      PS_STOPCLK = 3'd3,
      PS_SNOOP   = 3'd4,
      PS_RELOCK  = 3'd5,
      PS_EXIT    = 3'd6
   } pwr_state_e;
endpackage

// File: rtl/pwr_lock_timer.sv
module pwr_lock_timer #(
   parameter int LOCK_CYCLES = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic active,
   output logic done
);
   generate
      if (LOCK_CYCLES < 1) begin : g_bad
         $error("pwr_lock_timer: LOCK_CYCLES must be at least 1");
      end else if (LOCK_CYCLES == 1) begin : g_single
         logic unused_w;
         assign unused_w = clk ^ rst_n ^ load ^ active;
         assign done = 1'b1;
      end else begin : g_count
         localparam int CNT_W = $clog2(LOCK_CYCLES);
         localparam logic [CNT_W-1:0] START = CNT_W'(LOCK_CYCLES - 1);
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk) begin
            if (!rst_n)               cnt_q <= '0;
            else if (load)            cnt_q <= START;
            else if (active && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
         end
         assign done = (cnt_q == '0);
      end
   endgenerate
endmodule

// File: rtl/pwr_out_decode.sv
module pwr_out_decode
   import pwr_state_pkg::*;
(
   input  pwr_state_e state,
   input  logic       ext,
   output logic       core_en,
   output logic       bus_en,
   output logic       pll_en,
   output logic       lowv
);
   always_comb begin
      core_en = 1'b0;
      bus_en  = 1'b1;
      pll_en  = 1'b1;
      lowv    = ext;
      unique case (state)
         PS_RUN:     begin core_en = 1'b1; lowv = 1'b0; end
         PS_HALT,
         PS_STOPGNT: ;
         PS_STOPCLK: begin bus_en = 1'b0; pll_en = 1'b0; end
         PS_SNOOP:   core_en = 1'b1;
         PS_RELOCK:  bus_en = 1'b0;
         PS_EXIT:    lowv = 1'b0;
         default:    begin core_en = 1'b1; lowv = 1'b0; end
      endcase
   end
endmodule

// File: rtl/pwr_state_ctl.sv
module pwr_state_ctl
   import pwr_state_pkg::*;
#(
   parameter int LOCK_CYCLES = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               halt_req,
   input  logic               stop_pin,
   input  logic               deep_req,
   input  logic               snoop_req,
   input  logic               snoop_done,
   input  logic               intr,
   input  logic               ext_en,
   output logic               core_clk_en,
   output logic               bus_clk_en,
   output logic               pll_en,
   output logic               lowv_req,
   output logic [STATE_W-1:0] state_o,
   output logic               ext_o
);
   pwr_state_e state_q, state_d, ret_q, ret_d;
   logic       ext_q, ext_d;
   logic       lock_load, lock_done;

   assign lock_load = (state_q == PS_STOPCLK) && !stop_pin;

   pwr_lock_timer #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (lock_load),
      .active (state_q == PS_RELOCK),
      .done   (lock_done)
   );

   always_comb begin
      state_d = state_q;
      ret_d   = ret_q;
      ext_d   = ext_q;
      unique case (state_q)
         PS_RUN: begin
            if (stop_pin) begin
               state_d = PS_STOPGNT;
               ext_d   = ext_en;
            end else if (halt_req) begin
               state_d = PS_HALT;
               ext_d   = ext_en;
            end
         end
         PS_HALT: begin
            if (snoop_req) begin
               state_d = PS_SNOOP;
               ret_d   = PS_HALT;
            end else if (intr) begin
               state_d = ext_q ? PS_EXIT : PS_RUN;
            end
         end
         PS_STOPGNT: begin
            if (!stop_pin)      state_d = ext_q ? PS_EXIT : PS_RUN;
            else if (snoop_req) begin
               state_d = PS_SNOOP;
               ret_d   = PS_STOPGNT;
            end else if (deep_req) state_d = PS_STOPCLK;
         end
         PS_STOPCLK: if (!stop_pin) state_d = PS_RELOCK;
         PS_SNOOP:   if (snoop_done) state_d = ret_q;
         PS_RELOCK:  if (lock_done) state_d = ext_q ? PS_EXIT : PS_RUN;
         PS_EXIT:    state_d = PS_RUN;
         default:    state_d = PS_RUN;
      endcase
      if (state_d == PS_RUN) ext_d = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= PS_RUN;
         ret_q   <= PS_HALT;
         ext_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         ret_q   <= ret_d;
         ext_q   <= ext_d;
      end
   end

   pwr_out_decode u_dec (
      .state   (state_q),
      .ext     (ext_q),
      .core_en (core_clk_en),
      .bus_en  (bus_clk_en),
      .pll_en  (pll_en),
      .lowv    (lowv_req)
   );

   assign state_o = state_q;
   assign ext_o   = ext_q;
endmodule

// File: rtl/pwr_state_chk.sv
module pwr_state_chk #(
   parameter int LOCK_CYCLES = 8
) (
   input logic       clk,
   input logic       rst_n,
   input logic       stop_pin,
   input logic       deep_req,
   input logic       snoop_req,
   input logic       snoop_done,
   input logic       ext_en,
   input logic       core_clk_en,
   input logic       bus_clk_en,
   input logic       pll_en,
   input logic       lowv_req,
   input logic [2:0] state_o,
   input logic       ext_o
);
   int relock_cnt;
   always_ff @(posedge clk) begin
      if (!rst_n)               relock_cnt <= 0;
      else if (state_o == 3'd5) relock_cnt <= relock_cnt + 1;
      else                      relock_cnt <= 0;
   end

   AST_RUN_ALL_ON: assert property (@(posedge clk) disable iff (!rst_n)
      state_o == 3'd0 |-> core_clk_en && bus_clk_en && pll_en && !lowv_req); // R1
   AST_PIN_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      state_o == 3'd0 && stop_pin |=> state_o == 3'd2 && ext_o == $past(ext_en)); // R2
   AST_GATED_BUS_ON: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 3'd1 || state_o == 3'd2) |-> !core_clk_en && bus_clk_en && pll_en); // R3
   AST_DEEP_PLL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      state_o == 3'd3 |-> !pll_en && !core_clk_en); // R5
   AST_RELOCK_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      state_o != 3'd5 && relock_cnt != 0 |-> relock_cnt == LOCK_CYCLES); // R6
   AST_SNOOP_BACK: assert property (@(posedge clk) disable iff (!rst_n)
      state_o == 3'd4 && snoop_done |=> state_o == 3'd1 || state_o == 3'd2); // R7
   AST_SNOOP_LOWV: assert property (@(posedge clk) disable iff (!rst_n)
      state_o == 3'd4 |-> core_clk_en && lowv_req == ext_o); // R9
   AST_LOWV_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(core_clk_en) && state_o == 3'd0 |-> !$past(lowv_req)); // R10
   AST_DEEP_NO_SNOOP: assert property (@(posedge clk) disable iff (!rst_n)
      state_o == 3'd3 && stop_pin && snoop_req |=> state_o == 3'd3); // R11
   AST_DEEP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      state_o == 3'd2 && stop_pin && !snoop_req && deep_req |=> state_o == 3'd3); // R5
endmodule

bind pwr_state_ctl pwr_state_chk #(.LOCK_CYCLES(LOCK_CYCLES)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .stop_pin    (stop_pin),
   .deep_req    (deep_req),
   .snoop_req   (snoop_req),
   .snoop_done  (snoop_done),
   .ext_en      (ext_en),
   .core_clk_en (core_clk_en),
   .bus_clk_en  (bus_clk_en),
   .pll_en      (pll_en),
   .lowv_req    (lowv_req),
   .state_o     (state_o),
   .ext_o       (ext_o)
);

// File: tb/pwr_state_ctl_bench.sv
module pwr_state_ctl_bench;
   localparam int LOCK = 4;
   localparam int NVEC = 28;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic halt_req = 0, stop_pin = 0, deep_req = 0, snoop_req = 0;
   logic snoop_done = 0, intr = 0, ext_en = 0;
   logic core_clk_en, bus_clk_en, pll_en, lowv_req, ext_o;
   logic [2:0] state_o;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   pwr_state_ctl #(.LOCK_CYCLES(LOCK)) u_pwr_state_ctl (
      .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .stop_pin(stop_pin),
      .deep_req(deep_req), .snoop_req(snoop_req), .snoop_done(snoop_done),
      .intr(intr), .ext_en(ext_en), .core_clk_en(core_clk_en),
      .bus_clk_en(bus_clk_en), .pll_en(pll_en), .lowv_req(lowv_req),
      .state_o(state_o), .ext_o(ext_o)
   );

   // {req, inputs h s d sn sd i e, state, outputs core bus pll lowv ext}
   localparam logic [18:0] VEC [NVEC] = '{
      {4'd1,  7'b0000000, 3'd0, 5'b11100}, // R1 idle
      {4'd2,  7'b1100000, 3'd2, 5'b01100}, // R2 pin beats halt
      {4'd7,  7'b0111000, 3'd4, 5'b11100}, // R7 snoop beats deep
      {4'd7,  7'b0100100, 3'd2, 5'b01100}, // R7 back to stop-grant
      {4'd5,  7'b0110000, 3'd3, 5'b00000}, // R5 deep stop
      {4'd11, 7'b0101000, 3'd3, 5'b00000}, // R11 snoop ignored
      {4'd6,  7'b0000000, 3'd5, 5'b00100}, // R6 relock 1
      {4'd6,  7'b0000000, 3'd5, 5'b00100}, // R6 relock 2
      {4'd6,  7'b0000000, 3'd5, 5'b00100}, // R6 relock 3
      {4'd6,  7'b0000000, 3'd5, 5'b00100}, // R6 relock 4
      {4'd6,  7'b0000000, 3'd0, 5'b11100}, // R6 run after lock
      {4'd3,  7'b1000000, 3'd1, 5'b01100}, // R3 halt
      {4'd7,  7'b0001010, 3'd4, 5'b11100}, // R7 snoop beats intr
      {4'd7,  7'b0000100, 3'd1, 5'b01100}, // R7 back to halt
      {4'd4,  7'b0000010, 3'd0, 5'b11100}, // R4 intr wakes
      {4'd8,  7'b1000001, 3'd1, 5'b01111}, // R8 extended halt
      {4'd9,  7'b0001000, 3'd4, 5'b11111}, // R9 snoop keeps low voltage
      {4'd9,  7'b0000100, 3'd1, 5'b01111}, // R9 back to extended halt
      {4'd10, 7'b0000010, 3'd6, 5'b01101}, // R10 voltage first
      {4'd10, 7'b0000000, 3'd0, 5'b11100}, // R10 then core
      {4'd8,  7'b0100001, 3'd2, 5'b01111}, // R8 extended stop-grant
      {4'd8,  7'b0110000, 3'd3, 5'b00011}, // R8 extended deep stop
      {4'd6,  7'b0000000, 3'd5, 5'b00111}, // R6 ext relock 1
      {4'd6,  7'b0000000, 3'd5, 5'b00111}, // R6 ext relock 2
      {4'd6,  7'b0000000, 3'd5, 5'b00111}, // R6 ext relock 3
      {4'd6,  7'b0000000, 3'd5, 5'b00111}, // R6 ext relock 4
      {4'd10, 7'b0000000, 3'd6, 5'b01101}, // R10 exit cycle
      {4'd10, 7'b0000000, 3'd0, 5'b11100}  // R10 run
   };

   task automatic check(input string req, input logic [2:0] exp_st, input logic [4:0] exp_o);
      logic [4:0] act_o;
      act_o = {core_clk_en, bus_clk_en, pll_en, lowv_req, ext_o};
      checks++;
      if (state_o !== exp_st || act_o !== exp_o) begin
         errors++;
         $display("FAIL %s: state=%0d outs=%b expected state=%0d outs=%b",
                  req, state_o, act_o, exp_st, exp_o);
      end
   endtask

   task automatic drive(input logic [6:0] in);
      {halt_req, stop_pin, deep_req, snoop_req, snoop_done, intr, ext_en} = in;
   endtask

   task automatic step(input logic [6:0] in);
      @(negedge clk);
      drive(in);
      @(posedge clk);
      #5;
   endtask

   initial begin
      #2_000_000;
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      check("R1 reset", 3'd0, 5'b11100);

      for (int i = 0; i < NVEC; i++) begin
         step(VEC[i][14:8]);
         check($sformatf("R%0d vec%0d", VEC[i][18:15], i), VEC[i][7:5], VEC[i][4:0]);
      end

      // R4: pin release from plain stop-grant
      step(7'b0100000);
      check("R4 enter stop-grant", 3'd2, 5'b01100);
      step(7'b0000000);
      check("R4 pin release", 3'd0, 5'b11100);

      // R11: repeated snoop while deep, then release
      step(7'b0100000);
      step(7'b0110000);
      step(7'b0101000);
      check("R11 snoop held off", 3'd3, 5'b00000);
      step(7'b0101000);
      check("R11 still deep", 3'd3, 5'b00000);

      // R1: reset while in relock returns to run
      step(7'b0000000);
      check("R6 relock start", 3'd5, 5'b00100);
      @(negedge clk);
      rst_n = 1'b0;
      @(posedge clk);
      #5;
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      check("R1 reset from relock", 3'd0, 5'b11100);

      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule